// File: doc/BRIEF.md
# Reciprocal-Multiply Coefficient Quantizer

This block quantizes the coefficients produced by a two-dimensional forward transform without using a divider. Each step size is stored as a 13-bit numerator, the rounded value of 16384 divided by the step. The block multiplies the coefficient by this numerator and then shifts right by 14 bits, so one multiply and one shift take the place of a division. The input coefficient carries three fractional bits. These bits are folded into the same shift, which makes the total shift 17.

The numerator store holds three compression levels. Each level has two 64-entry tables, one for luminance and one for chrominance. A level select, a table select and the coefficient index address the store. Coefficients arrive as a stream with a valid flag. Each result leaves as a 12-bit signed value, tagged with the index it came in with, two clock cycles after it was presented. The block accepts one coefficient per cycle.

Top module: `qz_quantizer`

## Requirements
- R1: While reset is held, and after it is released with no input, `out_valid` is 0, and `out_value` and `out_index` are 0.
- R2: A coefficient presented with `in_valid` high in clock cycle k appears with `out_valid` high after the second rising edge. `out_index` equals the index that was presented. Back-to-back inputs give back-to-back outputs.
- R3: For level L (0..2), table T (0 or 1) and index i, with row r = i/8 and column c = i%8, the step is (r + c + 3 + T) << L. The numerator is floor((16384 + floor(step/2)) / step), so a step of 11 uses the numerator 1489. The store address is L*128 + T*64 + i.
- R4: The result is round(|coef| * N / 2^17), with ties rounded away from zero, and the input sign is applied afterwards. The result is therefore symmetric for positive and negative inputs.
- R5: A result above 2047 gives 2047. A result below -2048 gives -2048.
- R6: A level select value of 3 gives the same results as level 2.
- R7: The table select chooses between the two tables of a level. For the same coefficient and index, table 1 uses a coarser step than table 0.
- R8: When `out_valid` is low, `out_value` and `out_index` hold their last values.
- R9: A zero coefficient gives a zero result for every level, table and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Coefficient valid |
| in_coef | input | 19 | Signed coefficient with three fractional bits |
| in_index | input | 6 | Coefficient position in the 8x8 block (row*8 + column) |
| in_level | input | 2 | Compression level, where 3 is treated as 2 |
| in_table | input | 1 | Table select: 0 for luminance, 1 for chrominance |
| out_valid | output | 1 | Result valid |
| out_value | output | 12 | Signed quantized result |
| out_index | output | 6 | Index belonging to the result |

## Verification
Each result is due two rising edges after its input is sampled. The first edge registers the operands and looks up the numerator; the second edge registers the rounded and saturated product. The bench drives inputs on the falling edge and samples on the falling edge that follows the second rising edge. For a streamed burst it compares the output in each cycle with the input from two cycles earlier. It also checks that the outputs hold in the idle cycles after a burst. Expected values come from the step and rounding rules in the requirements, computed in the bench.

// File: rtl/qz_pkg.sv
package qz_pkg;
  localparam int COEF_W   = 19;
  localparam int FRAC_W   = 3;
  localparam int NUM_W    = 13;
  localparam int OUT_W    = 12;
  localparam int IDX_W    = 6;
  localparam int LVL_W    = 2;
  localparam int LVL_N    = 3;
  localparam int TBL_N    = 2;
  localparam int SHIFT    = 14;
  localparam int ENTRIES  = 1 << IDX_W;
  localparam int ROM_DEPTH = LVL_N * TBL_N * ENTRIES;
  localparam int ADDR_W   = $clog2(ROM_DEPTH);
  localparam int ROW_LEN  = 8;
  localparam int STEP_OFS = 3;

  // Numerator for one store address: rounded 2^SHIFT / step, clamped to NUM_W bits
  function automatic logic [NUM_W-1:0] numer_for(input int unsigned addr);
    int unsigned lvl, tb, ix, step, n;
    lvl  = addr / (TBL_N * ENTRIES);
    tb   = (addr / ENTRIES) % TBL_N;
    ix   = addr % ENTRIES;
    step = ((ix / ROW_LEN) + (ix % ROW_LEN) + STEP_OFS + tb) << lvl;
    n    = ((1 << SHIFT) + step / 2) / step;
    if (n > (1 << NUM_W) - 1) n = (1 << NUM_W) - 1;
    return NUM_W'(n);
  endfunction
endpackage

// File: rtl/qz_rst_sync.sv
module qz_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/qz_numer_rom.sv
module qz_numer_rom
  import qz_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic             tsel,
  input  logic [IDX_W-1:0] index,
  output logic [NUM_W-1:0] numer
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(LVL_N - 1);

  logic [NUM_W-1:0]  tbl [ROM_DEPTH];
  logic [LVL_W-1:0]  lvl_eff;
  logic [ADDR_W-1:0] addr;

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_entry
    assign tbl[g] = numer_for(g);
  end

  always_comb begin
    lvl_eff = (level > LVL_MAX) ? LVL_MAX : level;
    addr    = ADDR_W'(lvl_eff) * ADDR_W'(TBL_N * ENTRIES)
            + ADDR_W'(tsel) * ADDR_W'(ENTRIES)
            + ADDR_W'(index);
    numer   = tbl[addr];
  end
endmodule

// File: rtl/qz_round_sat.sv
module qz_round_sat
  import qz_pkg::*;
(
  input  logic [COEF_W-1:0] coef,
  input  logic [NUM_W-1:0]  numer,
  output logic [OUT_W-1:0]  value
);
  localparam int TOT    = SHIFT + FRAC_W;
  localparam int PROD_W = COEF_W + NUM_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic [SUM_W-1:0] HALF    = SUM_W'(1) << (TOT - 1);
  localparam logic [SUM_W-1:0] POS_LIM = (SUM_W'(1) << (OUT_W - 1)) - SUM_W'(1);
  localparam logic [SUM_W-1:0] NEG_LIM = SUM_W'(1) << (OUT_W - 1);

  logic             neg;
  logic [COEF_W-1:0] mag;
  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  rnd;
  logic [SUM_W-1:0]  lim;
  logic [OUT_W-1:0]  mag_out;

  always_comb begin
    neg  = coef[COEF_W-1];
    mag  = neg ? (~coef + COEF_W'(1)) : coef;
    prod = PROD_W'(mag) * PROD_W'(numer);
    rnd  = (SUM_W'(prod) + HALF) >> TOT;
    lim  = neg ? NEG_LIM : POS_LIM;
    if (rnd > lim) rnd = lim;
    mag_out = rnd[OUT_W-1:0];
    value   = neg ? (~mag_out + OUT_W'(1)) : mag_out;
  end
endmodule

// File: rtl/qz_quantizer.sv
module qz_quantizer
  import qz_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COEF_W-1:0] in_coef,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [LVL_W-1:0]  in_level,
  input  logic              in_table,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_value,
  output logic [IDX_W-1:0]  out_index
);
  logic rst_core_n;

  // operand stage
  logic              s1_vld_q, s1_vld_d;
  logic [COEF_W-1:0] s1_coef_q, s1_coef_d;
  logic [NUM_W-1:0]  s1_num_q, s1_num_d;
  logic [IDX_W-1:0]  s1_idx_q, s1_idx_d;
  logic [NUM_W-1:0]  rom_num;

  // result stage
  logic              s2_vld_q, s2_vld_d;
  logic [OUT_W-1:0]  s2_val_q, s2_val_d;
  logic [IDX_W-1:0]  s2_idx_q, s2_idx_d;
  logic [OUT_W-1:0]  rs_value;

  qz_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  qz_numer_rom u_rom (
    .level (in_level),
    .tsel  (in_table),
    .index (in_index),
    .numer (rom_num)
  );

  qz_round_sat u_rs (
    .coef  (s1_coef_q),
    .numer (s1_num_q),
    .value (rs_value)
  );

  always_comb begin
    s1_vld_d  = in_valid;
    s1_coef_d = s1_coef_q;
    s1_num_d  = s1_num_q;
    s1_idx_d  = s1_idx_q;
    if (in_valid) begin
      s1_coef_d = in_coef;
      s1_num_d  = rom_num;
      s1_idx_d  = in_index;
    end
  end

  always_comb begin
    s2_vld_d = s1_vld_q;
    s2_val_d = s2_val_q;
    s2_idx_d = s2_idx_q;
    if (s1_vld_q) begin
      s2_val_d = rs_value;
      s2_idx_d = s1_idx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      s1_vld_q  <= 1'b0;
      s1_coef_q <= '0;
      s1_num_q  <= '0;
      s1_idx_q  <= '0;
      s2_vld_q  <= 1'b0;
      s2_val_q  <= '0;
      s2_idx_q  <= '0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s1_coef_q <= s1_coef_d;
      s1_num_q  <= s1_num_d;
      s1_idx_q  <= s1_idx_d;
      s2_vld_q  <= s2_vld_d;
      s2_val_q  <= s2_val_d;
      s2_idx_q  <= s2_idx_d;
    end
  end

  assign out_valid = s2_vld_q;
  assign out_value = s2_val_q;
  assign out_index = s2_idx_q;
endmodule

// File: rtl/qz_quantizer_chk.sv
module qz_quantizer_chk
  import qz_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [COEF_W-1:0] in_coef,
  input logic [IDX_W-1:0]  in_index,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_value,
  input logic [IDX_W-1:0]  out_index
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  p_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_index == $past(in_index, 2));

  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_value != '0) |-> out_value[OUT_W-1] == $past(in_coef[COEF_W-1], 2));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_value) && $stable(out_index)));

  p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_coef, 2) == '0) |-> out_value == '0);
endmodule

bind qz_quantizer qz_quantizer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .in_coef   (in_coef),
  .in_index  (in_index),
  .out_valid (out_valid),
  .out_value (out_value),
  .out_index (out_index)
);

// File: tb/tb_qz_quantizer.sv
module tb_qz_quantizer;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [18:0] in_coef;
  logic [5:0]  in_index;
  logic [1:0]  in_level;
  logic        in_table;
  logic        out_valid;
  logic [11:0] out_value;
  logic [5:0]  out_index;

  int checks;
  int errors;

  qz_quantizer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_coef   (in_coef),
    .in_index  (in_index),
    .in_level  (in_level),
    .in_table  (in_table),
    .out_valid (out_valid),
    .out_value (out_value),
    .out_index (out_index)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // R3 model
  function automatic int numer_model(int lvl, int tb, int ix);
    int l, step, n;
    l = (lvl > 2) ? 2 : lvl;
    step = ((ix / 8) + (ix % 8) + 3 + tb) << l;
    n = (16384 + step / 2) / step;
    if (n > 8191) n = 8191;
    return n;
  endfunction

  // R4 / R5 model
  function automatic logic [11:0] quant_model(int coef, int lvl, int tb, int ix);
    longint mag, r;
    mag = (coef < 0) ? -coef : coef;
    r = (mag * numer_model(lvl, tb, ix) + 65536) >>> 17;
    if (coef < 0) begin
      if (r > 2048) r = 2048;
      return 12'(-r);
    end
    if (r > 2047) r = 2047;
    return 12'(r);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one isolated coefficient, checked two rising edges later
  task automatic one_coef(string req, int coef, int ix, int lvl, int tb, logic [11:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_coef = 19'(coef); in_index = 6'(ix);
    in_level = 2'(lvl); in_table = tb[0];
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " early valid"}, out_valid, 0);
    @(negedge clk);
    check({req, " valid"}, out_valid, 1);
    check({req, " index"}, out_index, ix);
    check({req, " value"}, $signed(out_value), $signed(exp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_coef = '0; in_index = '0;
    in_level = '0; in_table = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 value", out_value, 0);
    check("R1 index", out_index, 0);
  endtask

  task automatic t_step11();
    // index 36: r=4,c=4, level 0, table 0 -> step 11, N=1489; 55.0 -> 5
    check("R3 numerator", numer_model(0, 0, 36), 1489);
    one_coef("R3 step11", 440, 36, 0, 0, 12'd5);
    one_coef("R4 neg step11", -440, 36, 0, 0, -12'sd5);
  endtask

  task automatic t_round();
    one_coef("R4 pos", 1234, 9, 1, 0, quant_model(1234, 1, 0, 9));
    one_coef("R4 neg", -1234, 9, 1, 0, quant_model(-1234, 1, 0, 9));
    // index 0 level 0 table 0: step 3, N=5461; 1.5 units -> 12*5461=65532 -> round 0
    one_coef("R4 near half", 12, 0, 0, 0, quant_model(12, 0, 0, 0));
    one_coef("R4 frac", 100, 63, 2, 1, quant_model(100, 2, 1, 63));
  endtask

  task automatic t_sat();
    one_coef("R5 pos sat", 262143, 0, 0, 0, 12'sd2047);
    one_coef("R5 neg sat", -262144, 0, 0, 0, -12'sd2048);
  endtask

  task automatic t_level3();
    one_coef("R6 level3", 5000, 20, 3, 0, quant_model(5000, 2, 0, 20));
    one_coef("R6 level3 t1", -7777, 45, 3, 1, quant_model(-7777, 2, 1, 45));
  endtask

  task automatic t_table();
    one_coef("R7 table0", 3000, 1, 0, 0, quant_model(3000, 0, 0, 1));
    one_coef("R7 table1", 3000, 1, 0, 1, quant_model(3000, 0, 1, 1));
    check("R7 differ", quant_model(3000, 0, 0, 1) != quant_model(3000, 0, 1, 1), 1);
  endtask

  task automatic t_zero();
    one_coef("R9 zero a", 0, 0, 0, 0, 12'd0);
    one_coef("R9 zero b", 0, 63, 2, 1, 12'd0);
  endtask

  // back-to-back stream, then idle hold
  task automatic t_stream();
    int coefs[6] = '{800, -800, 20000, -3, 77, -65000};
    logic [11:0] last;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R2 stream valid", out_valid, 1);
        check("R2 stream index", out_index, (k - 2) * 7);
        check("R2 stream value", $signed(out_value),
              $signed(quant_model(coefs[k-2], k % 3, k % 2, (k - 2) * 7)));
      end
      if (k < 6) begin
        in_valid = 1'b1; in_coef = 19'(coefs[k]); in_index = 6'(k * 7);
        in_level = 2'((k + 2) % 3); in_table = k[0];
      end else begin
        in_valid = 1'b0; in_coef = 19'(1000); in_index = 6'd5;
      end
    end
    last = out_value;
    repeat (3) @(negedge clk);
    check("R8 hold valid", out_valid, 0);
    check("R8 hold value", out_value, last);
    check("R8 hold index", out_index, 35);
  endtask

  initial begin
    checks = 0; errors = 0;
    t_reset();
    t_step11();
    t_round();
    t_sat();
    t_level3();
    t_table();
    t_zero();
    t_stream();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule